// File: doc/BRIEF.md
# EDO DRAM Page-Mode Burst Sequencer

This block is the strobe engine for an asynchronous 16-bit DRAM with extended-data-out page mode. A host hands it a stream of column beats. Each beat carries a column, a write flag, two byte enables, write data and an end-of-burst flag. The first beat of a burst also supplies the row. The sequencer presents that row, drops RAS and keeps the row open. It then runs one CAS cycle per beat, either an early write or an EDO read. When the flagged beat finishes, it closes the row and precharges.

Every timing interval is a parameter counted in clock cycles: RAS-to-CAS delay, CAS low width, CAS precharge, RAS precharge, the extra gap inserted when a burst switches between reading and writing, and the longest time RAS may stay low. Read data is captured in the final cycle of CAS precharge, while EDO keeps the output valid. It is returned with a one-cycle valid pulse. If the row-open budget would run out before another beat could complete, the block closes the row early. It then reopens the row with the pending beat, so no beat is lost.

Top module: `edo_page_seq`

## Requirements
- R1: While reset is held and just after it is released, with no request pending: ras_n, ucas_n, lcas_n, we_n and oe_n are 1; dq_oe, rd_valid and req_ready are 0.
- R2: The row is taken from req_row only when a closed row is being opened. It is on dram_addr for at least one cycle before ras_n falls and stays there until the first column phase. req_row on every later beat of the same open row is ignored.
- R3: Each beat's column is on dram_addr at least one cycle before its CAS fall and does not change while CAS is low. CAS falls only while ras_n is 0. CAS falls occur in the order the beats were accepted.
- R4: CAS is low for exactly T_CAS cycles. Two back-to-back beats in the same direction start their CAS falls exactly T_CAS+T_CP+2 cycles apart.
- R5: When a beat's direction differs from the previous beat in the same open row, its CAS fall comes MIX_EXTRA cycles later than in R4.
- R6: req_be[1] gates ucas_n (bits 15:8) and req_be[0] gates lcas_n (bits 7:0). Enabled strobes fall and rise in the same cycle.
- R7: Writes are early writes. we_n is 0 for at least one cycle before the CAS fall, and dq_oe is 1 with the data on dq_out. oe_n stays 1 for the whole write beat.
- R8: In a read beat, oe_n is 0 and dq_oe is 0. dq_in is sampled in the last CAS-precharge cycle and returned on rd_data with a one-cycle rd_valid pulse in the next cycle. Bytes whose enable is 0 read as zero.
- R9: A beat with req_last set closes the row after its CAS precharge. ras_n then stays 1 for at least T_RP cycles before it falls again.
- R10: ras_n never stays 0 for more than RASP_MAX cycles. When the remaining budget cannot fit one more beat, the row is closed and reopened with the pending beat, and every beat is still carried out.
- R11: req_ready is 1 only while a row is open and the block is waiting for a column beat. A beat is accepted in a cycle where req_valid and req_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a column beat |
| req_ready | output | 1 | Beat accepted this cycle when valid |
| req_row | input | ADDR_W | Row address, used when a row is opened |
| req_col | input | ADDR_W | Column address of the beat |
| req_we | input | 1 | 1 = write beat, 0 = read beat |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 2*LANE_W | Write data |
| req_last | input | 1 | Close the row after this beat |
| rd_valid | output | 1 | One-cycle pulse, rd_data holds read data |
| rd_data | output | 2*LANE_W | Read data, disabled bytes zero |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dq_out | output | 2*LANE_W | Data driven toward the memory |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 2*LANE_W | Data returned by the memory |

## Verification
The bench places a small memory model on the strobes and runs several bursts: a write burst with partial byte enables and stray row values on later beats, a read-back burst, a burst that alternates direction, an over-long read burst that exhausts the RAS budget, and reads with single-byte enables. A sequencer that latched the row on every beat would write into the wrong row, and the read-back would show it. A missing mix gap shows up as a CAS period one cycle short. A missing budget guard leaves RAS low past its limit or loses the beat that was pending at the forced close. Sampling read data at the wrong cycle, or failing to mask disabled bytes, corrupts rd_data.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ROWSET, S_RCD, S_COLWAIT, S_CSET, S_CASLO, S_CASHI, S_PRE
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles from one CAS fall to the next for back-to-back beats
  function automatic int beat_span(input int t_cas, input int t_cp, input int mix);
    return t_cas + t_cp + 2 + mix;
  endfunction

  // last RAS-low count at which another beat may still start
  function automatic int guard_limit(input int rasp, input int t_cas, input int t_cp,
                                     input int mix);
    return rasp - (t_cas + t_cp + mix + 3);
  endfunction

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cnt == '0 && !load) |=> (cnt == '0)); // R4
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int RASP_MAX = 12500,
  parameter int LIMIT    = 12490
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic expire
);
  localparam int CW = $clog2(RASP_MAX + 1);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       low_cnt <= '0;
    else if (ras_low) low_cnt <= low_cnt + 1'b1;
    else              low_cnt <= '0;
  end

  assign expire = (low_cnt >= CW'(LIMIT));

  AST_RASP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) ras_low |-> (low_cnt < CW'(RASP_MAX))); // R10
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq import edo_seq_pkg::*; #(
  parameter int ADDR_W    = 12,
  parameter int LANE_W    = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 1,
  parameter int T_CP      = 1,
  parameter int T_RP      = 4,
  parameter int MIX_EXTRA = 1,
  parameter int RASP_MAX  = 12500
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_row,
  input  logic [ADDR_W-1:0]     req_col,
  input  logic                  req_we,
  input  logic [1:0]            req_be,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic                  req_last,
  output logic                  rd_valid,
  output logic [2*LANE_W-1:0]   rd_data,
  output logic                  ras_n,
  output logic                  ucas_n,
  output logic                  lcas_n,
  output logic                  we_n,
  output logic                  oe_n,
  output logic [ADDR_W-1:0]     dram_addr,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic                  dq_oe,
  input  logic [2*LANE_W-1:0]   dq_in
);
  localparam int DW      = 2 * LANE_W;
  localparam int TMR_MAX = max_of(max_of(T_RCD, T_CAS), max_of(max_of(T_CP, T_RP), MIX_EXTRA + 1));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int LIMIT   = guard_limit(RASP_MAX, T_CAS, T_CP, MIX_EXTRA);
  localparam int RPW     = $clog2(T_RP + 1);

  seq_state_t state, state_d;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              we_q, last_q, first_q, prevwe_q;
  logic [1:0]        be_q;
  logic [DW-1:0]     wd_q, rd_mask;
  logic              tmr_load, tmr_done, guard_exp;
  logic [TMR_W-1:0]  tmr_val;

  // named events
  logic row_open_req, beat_take, dir_change, in_beat, read_sample;
  assign row_open_req = (state == S_IDLE) && req_valid;
  assign req_ready    = (state == S_COLWAIT) && !guard_exp;
  assign beat_take    = req_ready && req_valid;
  assign dir_change   = !first_q && (req_we != prevwe_q);
  assign in_beat      = state inside {S_CSET, S_CASLO, S_CASHI};
  assign read_sample  = (state == S_CASHI) && tmr_done && !we_q;

  edo_phase_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  edo_ras_guard #(.RASP_MAX(RASP_MAX), .LIMIT(LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_low(!ras_n), .expire(guard_exp)
  );

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_IDLE:   if (req_valid) state_d = S_ROWSET;
      S_ROWSET: begin state_d = S_RCD; tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 1); end
      S_RCD:    if (tmr_done) state_d = S_COLWAIT;
      S_COLWAIT: begin
        if (guard_exp) begin
          state_d = S_PRE; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1);
        end else if (req_valid) begin
          state_d = S_CSET; tmr_load = 1'b1;
          tmr_val = dir_change ? TMR_W'(MIX_EXTRA) : '0;
        end
      end
      S_CSET:   if (tmr_done) begin state_d = S_CASLO; tmr_load = 1'b1; tmr_val = TMR_W'(T_CAS - 1); end
      S_CASLO:  if (tmr_done) begin state_d = S_CASHI; tmr_load = 1'b1; tmr_val = TMR_W'(T_CP - 1); end
      S_CASHI: begin
        if (tmr_done) begin
          if (last_q) begin state_d = S_PRE; tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); end
          else        state_d = S_COLWAIT;
        end
      end
      S_PRE:    if (tmr_done) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      we_q     <= 1'b0;
      be_q     <= '0;
      wd_q     <= '0;
      last_q   <= 1'b0;
      first_q  <= 1'b1;
      prevwe_q <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= state_d;
      rd_valid <= read_sample;
      if (row_open_req) begin
        row_q   <= req_row;
        first_q <= 1'b1;
      end
      if (beat_take) begin
        col_q    <= req_col;
        we_q     <= req_we;
        be_q     <= req_be;
        wd_q     <= req_wdata;
        last_q   <= req_last;
        first_q  <= 1'b0;
        prevwe_q <= req_we;
      end
      if (read_sample) rd_data <= dq_in & rd_mask;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rd_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
  end

  assign ras_n     = state inside {S_IDLE, S_ROWSET, S_PRE};
  assign ucas_n    = !((state == S_CASLO) && be_q[1]);
  assign lcas_n    = !((state == S_CASLO) && be_q[0]);
  assign we_n      = !(in_beat && we_q);
  assign oe_n      = !(in_beat && !we_q);
  assign dq_oe     = in_beat && we_q;
  assign dq_out    = wd_q;
  assign dram_addr = (state inside {S_IDLE, S_ROWSET, S_RCD}) ? row_q : col_q;

  // precharge tracker for the RAS-high assertion
  logic [RPW-1:0] ras_hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                                 ras_hi_cnt <= RPW'(T_RP);
    else if (!ras_n)                            ras_hi_cnt <= '0;
    else if (ras_hi_cnt < RPW'(T_RP))           ras_hi_cnt <= ras_hi_cnt + 1'b1;
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == S_RCD) |-> $stable(dram_addr)); // R2
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ucas_n || !lcas_n) |-> $stable(dram_addr)); // R3
  AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) (!ucas_n || !lcas_n) |-> !ras_n); // R3
  AST_LANES_U: assert property (@(posedge clk) disable iff (!rst_n) $rose(ucas_n) |-> lcas_n); // R6
  AST_LANES_L: assert property (@(posedge clk) disable iff (!rst_n) $rose(lcas_n) |-> ucas_n); // R6
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n) (($fell(ucas_n) || $fell(lcas_n)) && !we_n) |-> !$past(we_n)); // R7
  AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> (oe_n && dq_oe)); // R7
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !dq_oe); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R8
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> (ras_hi_cnt >= RPW'(T_RP))); // R9
  AST_READY_OPEN: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !ras_n); // R11
endmodule

// File: tb/edo_page_seq_tb.sv
module edo_page_seq_tb;
  localparam int AW = 12, LW = 8, DW = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, MIX = 1, RASP = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_we = 1'b0, req_last = 1'b0;
  logic [AW-1:0] req_row = '0, req_col = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_out;
  logic [DW-1:0] dq_in = '0;
  logic [AW-1:0] dram_addr;

  edo_page_seq #(.ADDR_W(AW), .LANE_W(LW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
                 .T_RP(T_RP), .MIX_EXTRA(MIX), .RASP_MAX(RASP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .req_last(req_last), .rd_valid(rd_valid), .rd_data(rd_data),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n),
    .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int i);
    return DW'(32'hA5C3 ^ (i * 32'h0137));
  endfunction
  function automatic logic [DW-1:0] bmask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  logic [DW-1:0] mem [64];
  logic [DW-1:0] shadow [64];
  initial for (int i = 0; i < 64; i++) begin mem[i] = init_word(i); shadow[i] = init_word(i); end

  logic [AW-1:0] exp_col [256];
  logic          exp_we  [256];
  logic [1:0]    exp_be  [256];
  logic [DW-1:0] exp_rd  [256];
  int n_acc = 0, n_rdexp = 0, n_rdgot = 0;
  logic [AW-1:0] cur_row = '0;

  task automatic send_beat(input logic [AW-1:0] row, input logic [AW-1:0] col, input logic we,
                           input logic [1:0] be, input logic [DW-1:0] d, input logic last);
    int idx;
    req_valid = 1'b1; req_row = row; req_col = col; req_we = we;
    req_be = be; req_wdata = d; req_last = last;
    while (!req_ready) @(negedge clk);
    idx = {26'd0, cur_row[1:0], col[3:0]};
    exp_col[n_acc] = col; exp_we[n_acc] = we; exp_be[n_acc] = be; n_acc++;
    if (we) shadow[idx] = (shadow[idx] & ~bmask(be)) | (d & bmask(be));
    else begin exp_rd[n_rdexp] = shadow[idx] & bmask(be); n_rdexp++; end
    @(negedge clk);
    req_valid = 1'b0; req_last = 1'b0;
  endtask

  // memory model and pin monitor, sampled mid-cycle
  int cyc = 0, n_fall = 0, n_rasfall = 0, hi_len = 1000, lo_len = 0, cas_lo = 0;
  int last_fall_cyc = 0, last_fall_ras = -1;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [AW-1:0] model_row = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        n_rasfall++;
        check(dram_addr == cur_row, "R2 row on address at RAS fall", 32'(dram_addr), 32'(cur_row));
        check(hi_len >= T_RP, "R9 RAS precharge length", hi_len, T_RP);
        model_row = dram_addr;
      end
      if (!prev_ras && ras_n)
        check(lo_len <= RASP, "R10 RAS low length", lo_len, RASP);
      if (prev_cas && (!ucas_n || !lcas_n)) begin
        int k, mi, span;
        k = n_fall; n_fall++;
        mi = {26'd0, model_row[1:0], dram_addr[3:0]};
        check(dram_addr == exp_col[k], "R3 column at CAS fall", 32'(dram_addr), 32'(exp_col[k]));
        check({!ucas_n, !lcas_n} == exp_be[k], "R6 lane strobes", 32'({!ucas_n, !lcas_n}), 32'(exp_be[k]));
        if (exp_we[k]) begin
          check(!prev_we && !we_n && oe_n && dq_oe, "R7 early write pins",
                32'({prev_we, we_n, oe_n, dq_oe}), 32'b0011);
          mem[mi] = (mem[mi] & ~bmask(exp_be[k])) | (dq_out & bmask(exp_be[k]));
        end else begin
          check(!oe_n && !dq_oe && we_n, "R8 read pins", 32'({oe_n, dq_oe, we_n}), 32'b001);
          dq_in <= mem[mi];
        end
        if (k > 0 && last_fall_ras == n_rasfall) begin
          span = T_CAS + T_CP + 2 + ((exp_we[k] != exp_we[k-1]) ? MIX : 0);
          if (exp_we[k] != exp_we[k-1])
            check(cyc - last_fall_cyc == span, "R5 mixed CAS period", cyc - last_fall_cyc, span);
          else
            check(cyc - last_fall_cyc == span, "R4 CAS period", cyc - last_fall_cyc, span);
        end
        last_fall_cyc = cyc; last_fall_ras = n_rasfall;
      end
      if (!prev_cas && ucas_n && lcas_n)
        check(cas_lo == T_CAS, "R4 CAS low width", cas_lo, T_CAS);
      if (rd_valid) begin
        check(rd_data == exp_rd[n_rdgot], "R8 read data", 32'(rd_data), 32'(exp_rd[n_rdgot]));
        check(ucas_n && lcas_n, "R8 valid during CAS high", 32'({ucas_n, lcas_n}), 32'b11);
        n_rdgot++;
      end
    end
    hi_len = ras_n ? hi_len + 1 : 0;
    lo_len = ras_n ? 0 : lo_len + 1;
    cas_lo = (ucas_n && lcas_n) ? 0 : cas_lo + 1;
    prev_ras = ras_n; prev_cas = ucas_n && lcas_n; prev_we = we_n;
  end

  logic done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0;
    logic [1:0] be;
    repeat (3) @(negedge clk);
    check(ras_n && ucas_n && lcas_n && we_n && oe_n, "R1 strobes idle in reset",
          32'({ras_n, ucas_n, lcas_n, we_n, oe_n}), 32'h1f);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ras_n && ucas_n && lcas_n, "R1 RAS/CAS high", 32'({ras_n, ucas_n, lcas_n}), 32'h7);
    check(we_n && oe_n, "R1 WE/OE high", 32'({we_n, oe_n}), 32'h3);
    check(!dq_oe && !rd_valid, "R1 no drive, no valid", 32'({dq_oe, rd_valid}), 0);
    check(!req_ready, "R11 not ready while idle", 32'(req_ready), 0);

    // burst A: writes to row 1, later beats carry a stray row (R2)
    cur_row = 12'd1;
    for (int i = 0; i < 6; i++) begin
      be = (i == 1) ? 2'b01 : (i == 2) ? 2'b10 : 2'b11;
      send_beat((i == 0) ? 12'd1 : 12'd2, 12'(i), 1'b1, be, 16'h1000 + 16'(i * 16'h0111), i == 5);
    end
    repeat (3) @(negedge clk);
    check(!req_ready, "R11 not ready after last beat", 32'(req_ready), 0);
    repeat (10) @(negedge clk);
    check(ras_n, "R9 row closed after last", 32'(ras_n), 1);

    // burst B: read back row 1
    for (int i = 0; i < 6; i++) send_beat(12'd1, 12'(i), 1'b0, 2'b11, '0, i == 5);
    repeat (12) @(negedge clk);

    // burst C: mixed directions in row 2 (R5)
    cur_row = 12'd2;
    for (int i = 0; i < 6; i++) begin
      logic w;
      w = (i == 0 || i == 3 || i == 5);
      send_beat(12'd2, 12'(i + 4), w, w ? 2'b11 : 2'(i % 3 + 1), 16'h5A00 + 16'(i), i == 5);
    end
    repeat (12) @(negedge clk);

    // burst D: long read burst forces a row close (R10)
    cur_row = 12'd3;
    f0 = n_rasfall;
    for (int i = 0; i < 12; i++) send_beat(12'd3, 12'(i), 1'b0, 2'(i % 3 + 1), '0, i == 11);
    repeat (12) @(negedge clk);
    check(n_rasfall - f0 == 2, "R10 forced close and reopen", n_rasfall - f0, 2);

    // burst E: write then single-byte reads in row 0 (R8 masking)
    cur_row = 12'd0;
    send_beat(12'd0, 12'd15, 1'b1, 2'b11, 16'hBEEF, 1'b0);
    send_beat(12'd0, 12'd15, 1'b0, 2'b01, '0, 1'b0);
    send_beat(12'd0, 12'd15, 1'b0, 2'b10, '0, 1'b1);
    repeat (12) @(negedge clk);

    check(n_fall == n_acc, "R3 one CAS cycle per beat", n_fall, n_acc);
    check(n_rdgot == n_rdexp, "R8 one valid per read", n_rdgot, n_rdexp);
    check(ras_n && !req_ready, "R11 idle at end", 32'({ras_n, req_ready}), 32'b10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule